// File: doc/BRIEF.md
# Lock-Qualified Reset Sequencer

This block sits beside a clock manager and produces the reset and the pacing for logic that may only run once the manager is stable. One active-high external reset goes to both the clock manager and this block. The block holds its reset output active until the manager's lock indication has been present, after a two-stage synchronizer, for a set number of fast-clock cycles. Any loss of lock restarts the whole wait.

Slow logic is not given its own clock. It runs on the fast clock and advances only on cycles where the enable output is high. By default that is one cycle in four. The enable counter starts from zero at every reset release, so the first advance lands at a fixed and known point after release.

Top module: `lock_rst_seq`

## Requirements
- R1: A high `ext_rst` sampled at a rising edge drives `rst_out` high and `ce_out` low after that same edge, and both stay that way while `ext_rst` remains high.
- R2: With `lock_in` held high, `rst_out` goes low after the (DELAY+2)-th rising edge, counting the first edge that samples `ext_rst` low as edge 1.
- R3: `lock_in` goes through a two-flop synchronizer. When `lock_in` rises, `rst_out` goes low after the (DELAY+2)-th edge, counting the first edge that samples it high as edge 1. That is exactly DELAY cycles after the synchronized lock.
- R4: A low `lock_in` sampled at any edge drives `rst_out` high after the third edge, counting the sampling edge as edge 1. Before that, `rst_out` keeps its released value.
- R5: A loss of lock, even one lasting a single cycle, clears the delay chain. If `lock_in` is low for L sampled edges and then high, `rst_out` goes low after edge L+DELAY+2, counting the first low sample as edge 1.
- R6: While `ext_rst` is high, `lock_in` has no effect and `rst_out` stays high.
- R7: `ce_out` is never high in a cycle in which `rst_out` is high.
- R8: If `rst_out` goes low after edge R, `ce_out` is high for exactly one cycle after edges R+DIV, R+2·DIV and so on, and low after every other edge. DIV defaults to 4.
- R9: Any DELAY from 1 to 32 obeys R2, R3 and R5 with its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; every flop in the block uses it |
| ext_rst | input | 1 | Active-high synchronous reset shared with the clock manager |
| lock_in | input | 1 | Lock indication from the clock manager, asynchronous |
| rst_out | output | 1 | Active-high synchronous reset for the downstream logic |
| ce_out | output | 1 | One-in-DIV clock enable for the slow logic |

## Verification
A delay chain that does not clear would show up as a reset that releases early after a short loss of lock. This is visible within one DELAY window of the lock returning. A release that is off by one shows up as `rst_out` falling one cycle early or late against a count taken from the first sampled edge. A wrong enable counter shows up at the first pulse, four cycles after release, or as a pulse that leaks into a reset cycle. Three delay values are run side by side so that an error which depends on DELAY stands out within a few dozen cycles.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int unsigned RSQ_DELAY_MAX = 32;
  localparam int unsigned RSQ_RUN_W     = $clog2(RSQ_DELAY_MAX + 2) + 1;
  localparam int unsigned RSQ_SINCE_W   = 8;

  function automatic int unsigned rsq_cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rsq_lock_sync.sv
module rsq_lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rsq_lock_delay.sv
module rsq_lock_delay
  import rsq_pkg::*;
#(
  parameter int unsigned DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_s,
  output logic done
);
  logic [DELAY-1:0] sr;

  generate
    if (DELAY == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst || !lock_s) sr <= '0;
        else                sr <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst || !lock_s) sr <= '0;
        else                sr <= {sr[DELAY-2:0], 1'b1};
      end
    end
  endgenerate

  assign done = sr[DELAY-1];

  // Checker state: length of the current run of synchronized lock.
  localparam logic [RSQ_RUN_W-1:0] RUN_SAT = '1;
  logic [RSQ_RUN_W-1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst || !lock_s)      run_cnt <= '0;
    else if (run_cnt != RUN_SAT) run_cnt <= run_cnt + 1'b1;
  end

  assert_lock_loss_R4: assert property (@(posedge clk) disable iff (rst)
    !lock_s |=> !done);

  assert_release_count_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> run_cnt == RSQ_RUN_W'(DELAY));

  assert_hold_after_release_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> run_cnt >= RSQ_RUN_W'(DELAY));
endmodule

// File: rtl/rsq_ce_gen.sv
module rsq_ce_gen
  import rsq_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic hold,
  output logic ce_o
);
  localparam int unsigned      CW   = rsq_cnt_width(DIV);
  localparam logic [CW-1:0]    LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          ce_q;

  always_ff @(posedge clk) begin
    if (hold) begin
      cnt  <= '0;
      ce_q <= 1'b0;
    end else begin
      ce_q <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign ce_o = ce_q & ~hold;

  // Checker state: edges since release, saturating.
  localparam logic [RSQ_SINCE_W-1:0] SINCE_SAT = '1;
  logic [RSQ_SINCE_W-1:0] since;
  always_ff @(posedge clk) begin
    if (hold)                  since <= '0;
    else if (since != SINCE_SAT) since <= since + 1'b1;
  end

  assert_first_pulse_R8: assert property (@(posedge clk) disable iff (hold)
    ce_o |-> since >= RSQ_SINCE_W'(DIV));

  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (hold)
    ce_o |=> !ce_o);
endmodule

// File: rtl/lock_rst_seq.sv
module lock_rst_seq #(
  parameter int unsigned DELAY       = 16,
  parameter int unsigned DIV         = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic ext_rst,
  input  logic lock_in,
  output logic rst_out,
  output logic ce_out
);
  logic lock_s;
  logic done;

  rsq_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (ext_rst),
    .d_async (lock_in),
    .q_sync  (lock_s)
  );

  rsq_lock_delay #(.DELAY(DELAY)) u_delay (
    .clk    (clk),
    .rst    (ext_rst),
    .lock_s (lock_s),
    .done   (done)
  );

  assign rst_out = ~done;

  rsq_ce_gen #(.DIV(DIV)) u_ce (
    .clk  (clk),
    .hold (rst_out),
    .ce_o (ce_out)
  );

  assert_ext_rst_forces_R1: assert property (@(posedge clk)
    ext_rst |=> rst_out && !ce_out);

  assert_ce_quiet_R7: assert property (@(posedge clk) disable iff (ext_rst)
    rst_out |-> !ce_out);

  assert_lock_ignored_in_reset_R6: assert property (@(posedge clk)
    (ext_rst && lock_in) |=> rst_out);
endmodule

// File: tb/lock_rst_seq_tb.sv
module lock_rst_seq_tb;
  localparam int NDUT = 3;

  function automatic int dl(input int i);
    case (i)
      0:       return 1;
      1:       return 7;
      default: return 32;
    endcase
  endfunction

  logic clk;
  logic ext_rst;
  logic lock_in;
  logic [NDUT-1:0] rst_v;
  logic [NDUT-1:0] ce_v;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  for (genvar g = 0; g < NDUT; g++) begin : g_dut
    lock_rst_seq #(.DELAY(dl(g)), .DIV(4), .SYNC_STAGES(2)) u_dut (
      .clk     (clk),
      .ext_rst (ext_rst),
      .lock_in (lock_in),
      .rst_out (rst_v[g]),
      .ce_out  (ce_v[g])
    );
  end

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, act=%0d exp<=5000", cyc);
      summary();
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int dut, input string sig,
                     input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s dut%0d %s act=%b exp=%b t=%0t", req, dut, sig, act, exp, $time);
    end
  endtask

  task automatic lock_drop(input int len);
    lock_in = 1'b0;
    for (int n = 1; n <= len + 46; n++) begin
      step();
      if (n == len) lock_in = 1'b1;
      for (int g = 0; g < NDUT; g++) begin
        int rel;
        rel = len + dl(g) + 2;
        if (n < 3) begin
          chk("R4", g, "rst_out", rst_v[g], 1'b0);
        end else begin
          chk("R5", g, "rst_out", rst_v[g], logic'(n < rel));
          chk("R8", g, "ce_out", ce_v[g],
              logic'((n >= rel + 4) && ((n - rel) % 4 == 0)));
        end
      end
    end
  endtask

  initial begin
    ext_rst = 1'b1;
    lock_in = 1'b0;

    // R1: reset state while the shared reset is high.
    repeat (3) step();
    for (int g = 0; g < NDUT; g++) begin
      chk("R1", g, "rst_out", rst_v[g], 1'b1);
      chk("R1", g, "ce_out",  ce_v[g],  1'b0);
    end

    // R6: lock arriving during reset changes nothing.
    lock_in = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      for (int g = 0; g < NDUT; g++) chk("R6", g, "rst_out", rst_v[g], 1'b1);
    end

    // R2, R3, R9, R7, R8: release after DELAY+2 edges, then enables.
    ext_rst = 1'b0;
    for (int n = 1; n <= 50; n++) begin
      step();
      for (int g = 0; g < NDUT; g++) begin
        int rel;
        rel = dl(g) + 2;
        chk("R2", g, "rst_out", rst_v[g], logic'(n < rel));
        chk("R7", g, "ce_out",  ce_v[g],
            logic'((n >= rel + 4) && ((n - rel) % 4 == 0)));
      end
    end

    // R4, R5: single-cycle glitch and a longer loss of lock.
    lock_drop(1);
    lock_drop(3);

    // R1: a one-cycle reset pulse while running, then a full re-release.
    ext_rst = 1'b1;
    step();
    ext_rst = 1'b0;
    for (int g = 0; g < NDUT; g++) begin
      chk("R1", g, "rst_out", rst_v[g], 1'b1);
      chk("R1", g, "ce_out",  ce_v[g],  1'b0);
    end
    for (int n = 2; n <= 50; n++) begin
      step();
      for (int g = 0; g < NDUT; g++) begin
        int rel;
        rel = dl(g) + 3;
        chk("R9", g, "rst_out", rst_v[g], logic'(n < rel));
        chk("R8", g, "ce_out",  ce_v[g],
            logic'((n >= rel + 4) && ((n - rel) % 4 == 0)));
      end
    end

    summary();
    $finish;
  end
endmodule